// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps time for an always-on slow domain. A 47-bit counter advances once for each pulse on a 32 kHz tick input. Its low 15 bits form the fraction of a second and its upper 32 bits count whole seconds. A programmable alarm is compared against the seconds word, and a sticky alarm flag can drive a level interrupt. Status flags mark the block as not valid after power-up or after a security violation. While either condition holds, time does not advance.

Software reaches every register through a simple word-wide bus. A write takes effect on the clock edge at which it is presented. Reads are combinational and change no state. The counter stays frozen after reset until three conditions are met: software has written a time register at least once, software has set the enable bit, and software has cleared the not-valid state.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset, time reads 0 at offset 0x00 and at offset 0x04, alarm seconds (0x08) reads 0xFFFFFFFF and alarm fraction (0x0C) reads 0x00007FFF. Control (0x10) and interrupt enable (0x18) read 0. Status (0x14) reads 0x2, meaning only the not-valid bit 1 is set. irq_o is low.
- R2: On a cycle with tick_i high, the 47-bit count {seconds, fraction} increases by exactly one only when all of these hold: control bit 3 is set, the counter is armed, and status bit 1 is clear. Otherwise the count holds. A fraction of 0x7FFF carries into the seconds word.
- R3: After reset the counter is unarmed and does not advance even when enabled. Any write to offset 0x00 or offset 0x04 arms it.
- R4: A write to 0x00 loads the seconds word. A write to 0x04 loads bits 14:0 into the fraction. When a write and a tick fall in the same cycle, the write wins.
- R5: The alarm seconds word (0x08) and the 15-bit alarm fraction (0x0C) read back as written. The alarm fraction has no effect on the alarm flag.
- R6: Status bit 4 sets one cycle after the seconds word starts to equal the alarm seconds word, and it stays set. Writing 1 to bit 4 of 0x14 clears it. If a new match and the clear land in the same cycle, the match wins.
- R7: irq_o is high exactly when status bit 4 and interrupt-enable bit 4 are both set. No event other than the alarm raises irq_o.
- R8: A write to 0x14 with bits 1 and 0 both set clears the not-valid and security-violation flags. A write with only one of those two bits set leaves both flags unchanged.
- R9: viol_i high at a clock edge sets status bit 0 and status bit 1. This takes priority over a clearing write in the same cycle, and it stops the counter.
- R10: Bits that do not map to a register field read 0: control apart from bit 3, status apart from bits 4, 1 and 0, enable apart from bit 4, and bits 31:15 of the fraction words. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32 kHz count pulse |
| viol_i | input | 1 | Security violation event |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
Reads are combinational, so a register written or counted at a clock edge reads back at the following falling edge. The alarm flag and irq_o lag by one more cycle, because the match of seconds against alarm is itself registered. The bench drives each stimulus at a falling edge and advances its reference model at the rising edge. At the next falling edge it peeks every offset and irq_o, so each result is compared in the cycle it is due. That includes the flag, which the model sets one step after the seconds match.

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          viol_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int CNT_W = SEC_W + FRAC_W;
  localparam logic [AW-1:0] A_TSEC  = AW'(5'h00);
  localparam logic [AW-1:0] A_TFRAC = AW'(5'h04);
  localparam logic [AW-1:0] A_ASEC  = AW'(5'h08);
  localparam logic [AW-1:0] A_AFRAC = AW'(5'h0C);
  localparam logic [AW-1:0] A_CTRL  = AW'(5'h10);
  localparam logic [AW-1:0] A_STAT  = AW'(5'h14);
  localparam logic [AW-1:0] A_IEN   = AW'(5'h18);
  localparam int B_RUN  = 3;
  localparam int B_ALM  = 4;
  localparam int B_NV   = 1;
  localparam int B_SV   = 0;

  logic [CNT_W-1:0]  cnt_q;
  logic [SEC_W-1:0]  alm_sec_q;
  logic [FRAC_W-1:0] alm_frac_q;
  logic run_q, armed_q, nv_q, sv_q, alm_flag_q, match_q, ien_q;

  wire [SEC_W-1:0]  sec_w  = cnt_q[CNT_W-1:FRAC_W];
  wire [FRAC_W-1:0] frac_w = cnt_q[FRAC_W-1:0];

  wire wr_tsec  = wr_en_i && addr_i == A_TSEC;
  wire wr_tfrac = wr_en_i && addr_i == A_TFRAC;
  wire wr_time  = wr_tsec || wr_tfrac;
  wire wr_stat  = wr_en_i && addr_i == A_STAT;
  wire advance  = tick_i && run_q && armed_q && !nv_q;
  wire match_w  = (sec_w == alm_sec_q);
  wire alm_set  = match_w && !match_q;
  wire revalid  = wr_stat && wdata_i[B_NV] && wdata_i[B_SV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_tsec) begin
      cnt_q[CNT_W-1:FRAC_W] <= wdata_i[SEC_W-1:0];
      armed_q <= 1'b1;
    end else if (wr_tfrac) begin
      cnt_q[FRAC_W-1:0] <= wdata_i[FRAC_W-1:0];
      armed_q <= 1'b1;
    end else if (advance) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_sec_q  <= '1;
      alm_frac_q <= '1;
      run_q      <= 1'b0;
      ien_q      <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_ASEC)  alm_sec_q  <= wdata_i[SEC_W-1:0];
      if (addr_i == A_AFRAC) alm_frac_q <= wdata_i[FRAC_W-1:0];
      if (addr_i == A_CTRL)  run_q      <= wdata_i[B_RUN];
      if (addr_i == A_IEN)   ien_q      <= wdata_i[B_ALM];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q    <= 1'b0;
      alm_flag_q <= 1'b0;
      nv_q       <= 1'b1;
      sv_q       <= 1'b0;
    end else begin
      match_q <= match_w;
      if (alm_set)                        alm_flag_q <= 1'b1;
      else if (wr_stat && wdata_i[B_ALM]) alm_flag_q <= 1'b0;
      if (viol_i) begin
        nv_q <= 1'b1;
        sv_q <= 1'b1;
      end else if (revalid) begin
        nv_q <= 1'b0;
        sv_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TSEC:  rdata_o[SEC_W-1:0]  = sec_w;
      A_TFRAC: rdata_o[FRAC_W-1:0] = frac_w;
      A_ASEC:  rdata_o[SEC_W-1:0]  = alm_sec_q;
      A_AFRAC: rdata_o[FRAC_W-1:0] = alm_frac_q;
      A_CTRL:  rdata_o[B_RUN]      = run_q;
      A_STAT: begin
        rdata_o[B_ALM] = alm_flag_q;
        rdata_o[B_NV]  = nv_q;
        rdata_o[B_SV]  = sv_q;
      end
      A_IEN:   rdata_o[B_ALM]      = ien_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = alm_flag_q & ien_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_time && !(tick_i && run_q)) |=> $stable(cnt_q));
  // R2
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_time |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  unarmed_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !wr_time) |=> $stable(cnt_q));
  // R6
  alarm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag_q) |-> $past(sec_w == alm_sec_q));
  // R8
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nv_q) |-> $past(wr_stat && wdata_i[B_NV] && wdata_i[B_SV]));
  // R9
  viol_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> (nv_q && sv_q));
endmodule

// File: tb/sec_alarm_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_rtc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, viol = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sec_alarm_rtc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .viol_i(viol),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  logic [31:0] m_sec, m_alm;
  logic [14:0] m_frac, m_afrac;
  bit m_armed, m_run, m_nv, m_sv, m_flag, m_match, m_ien;

  task automatic model_reset();
    m_sec = 0; m_frac = 0; m_alm = 32'hFFFF_FFFF; m_afrac = 15'h7FFF;
    m_armed = 0; m_run = 0; m_nv = 1; m_sv = 0; m_flag = 0; m_match = 0; m_ien = 0;
  endtask

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    case (a)
      5'h00: return m_sec;
      5'h04: return {17'd0, m_frac};
      5'h08: return m_alm;
      5'h0C: return {17'd0, m_afrac};
      5'h10: return {28'd0, m_run, 3'd0};
      5'h14: return {27'd0, m_flag, 2'd0, m_nv, m_sv};
      5'h18: return {27'd0, m_ien, 4'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00, 5'h04: return "R2/R4";
      5'h08, 5'h0C: return "R5";
      5'h14: return "R6/R8/R9";
      5'h10, 5'h18: return "R10";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=0x%08h exp=0x%08h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      peek(5'(i * 4), v);
      chk({req, " ", tag_of(5'(i * 4))}, v, exp_rd(5'(i * 4)));
    end
    chk({req, " R7 irq"}, {31'd0, irq}, {31'd0, m_flag & m_ien});
  endtask

  task automatic step(bit w, logic [4:0] a, logic [31:0] d, bit tk, bit vi);
    logic [46:0] c;
    bit n_flag;
    we = w; addr = a; wdata = d; tick = tk; viol = vi;
    c = {m_sec, m_frac};
    n_flag = m_flag;
    if (w && a == 5'h14 && d[4]) n_flag = 0;
    if (m_sec == m_alm && !m_match) n_flag = 1;
    m_match = (m_sec == m_alm);
    m_flag = n_flag;
    if (w && a == 5'h00) begin m_sec = d; m_armed = 1; end
    else if (w && a == 5'h04) begin m_frac = d[14:0]; m_armed = 1; end
    else if (tk && m_run && m_armed && !m_nv) begin c = c + 47'd1; {m_sec, m_frac} = c; end
    if (w && a == 5'h08) m_alm = d;
    if (w && a == 5'h0C) m_afrac = d[14:0];
    if (w && a == 5'h10) m_run = d[3];
    if (w && a == 5'h18) m_ien = d[4];
    if (vi) begin m_nv = 1; m_sv = 1; end
    else if (w && a == 5'h14 && d[1] && d[0]) begin m_nv = 0; m_sv = 0; end
    @(posedge clk);
    @(negedge clk);
    we = 0; tick = 0; viol = 0;
  endtask

  initial begin
    #(20 * 190000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    // R2: not enabled, not valid: tick has no effect
    step(0, 0, 0, 1, 0); check_all("R2 idle tick");
    step(1, 5'h10, 32'h8, 0, 0);
    step(1, 5'h14, 32'h1, 0, 0); check_all("R8 single bit");
    step(1, 5'h14, 32'h2, 0, 0); check_all("R8 single bit");
    step(1, 5'h14, 32'h3, 0, 0);
    peek(5'h14, v); chk("R8 revalid", v, 32'h0);
    // R3: unarmed
    step(0, 0, 0, 1, 0);
    peek(5'h04, v); chk("R3 unarmed", v, 32'h0);
    step(1, 5'h04, 32'hFFFF_7FFE, 0, 0);
    peek(5'h04, v); chk("R4 frac load", v, 32'h7FFE);
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
    peek(5'h00, v); chk("R2 carry sec", v, 32'd1);
    peek(5'h04, v); chk("R2 carry frac", v, 32'd0);
    step(1, 5'h00, 32'd50, 1, 0);
    peek(5'h04, v); chk("R4 write wins", v, 32'd0);
    // alarm
    step(1, 5'h08, 32'd51, 0, 0);
    step(1, 5'h0C, 32'd5, 0, 0);
    step(1, 5'h18, 32'h10, 0, 0);
    step(1, 5'h04, 32'h7FFF, 0, 0);
    peek(5'h14, v); chk("R5 frac ignored", v, 32'h0);
    step(0, 0, 0, 1, 0);
    peek(5'h14, v); chk("R6 one cycle late", v, 32'h0);
    step(0, 0, 0, 0, 0);
    peek(5'h14, v); chk("R6 flag set", v, 32'h10);
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    step(1, 5'h14, 32'h10, 0, 0);
    peek(5'h14, v); chk("R6 w1c", v, 32'h0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);
    step(1, 5'h1C, 32'hFFFF_FFFF, 0, 0); check_all("R10 unmapped");
    step(1, 5'h14, 32'h3, 1, 1);
    peek(5'h14, v); chk("R9 viol wins", v, 32'h3);
    step(0, 0, 0, 1, 0); check_all("R9 stopped");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      logic [4:0] a = 5'($urandom_range(0, 7) * 4);
      logic [31:0] d = $urandom();
      bit w = (r < 30);
      if (a == 5'h08) d = m_sec + 32'($urandom_range(0, 3));
      if (a == 5'h00 && r < 15) d = m_alm - 32'($urandom_range(0, 2));
      if (a == 5'h04 && r < 20) d = 32'h7FF0 + 32'($urandom_range(0, 15));
      if (a == 5'h14 && r < 20) d = 32'h3;
      if (a == 5'h10) d = (r < 25) ? 32'h8 : d;
      step(w, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 199) == 0);
      check_all("rand");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule